// File: doc/BRIEF.md
# Strip Pedestal and Common-Mode Corrector

This block takes the digitised samples of the 128 strip channels of one front-end chip. One frame arrives per bunch crossing, and the block returns signed samples with two offsets removed: the per-channel baseline and the offset that all channels of a frame share. Samples enter as a stream. A marker flags channel 0 of each frame, and each accepted sample advances the channel index by one.

The block has two modes, and the mode is latched when a frame starts.
- **Training mode** runs over a window of 2^TRAIN_LOG2 signal-free frames. It sums every channel's readings over the window and keeps each channel's average at half-count resolution.
- **Run mode** subtracts the stored baseline with half-count rounding and buffers the frame. Once the frame is complete, it subtracts the rounded frame mean from every channel.

An optional reduced-precision rescale maps the raw 10-bit words onto a 6-bit range before any other step. Training and running must use the same rescale setting. A corrected frame leaves the block while the next frame enters, paced by that frame's samples.

Top module: `strip_cm_corrector`

## Requirements
- R1: After reset, outValid, outFirst, outSat and frameErr are all 0.
- R2: With reducedMode=1, each raw word x is first mapped to s.
  - If x < 480, then s = 0.
  - Otherwise s = min(floor((x-480)/q), 63), where q = 2 when divByTwo=1 and q = 3 when divByTwo=0.
  - With reducedMode=0, s = x.
- R3: Training uses windows of N = 2^TRAIN_LOG2 completed frames. The first frame of a window restarts each channel's sum. At the end of the window, the stored baseline P equals floor(2*sum/N), which is twice the average, truncated.
- R4: In run mode, each channel's baseline-corrected value is v = floor(s - P/2 + 1/2).
- R5: For each complete run frame, m = floor((sum of the 128 v values + 64)/128), and every channel's output equals v - m.
- R6: Output timing follows the input stream.
  - Channel k of a complete run frame is output one cycle after sample k of the following run frame is accepted.
  - outFirst marks channel 0.
  - Nothing is output during a training frame, or during the first run frame after a training frame.
- R7: Results outside the signed OUTW range are clamped to the nearest limit (127 or -128 at OUTW=8), and outSat is 1 on that output.
- R8: A frame-start marker that arrives before all 128 samples of a frame have been accepted has the following effects.
  - frameErr is 1 for exactly the next cycle.
  - The marker begins a new frame at channel 0.
  - The partial frame is discarded, so no output is produced during the new frame.
  - Any training window restarts.
- R9: Cycles with inValid=0 do not advance the channel index and produce outValid=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trainMode | input | 1 | 1 = training frame, sampled at the frame start |
| reducedMode | input | 1 | Enable the offset-and-divide rescale |
| divByTwo | input | 1 | Rescale divisor: 1 selects 2, 0 selects 3 |
| inValid | input | 1 | Input sample valid |
| inFirst | input | 1 | Sample is channel 0 of a new frame |
| inData | input | INW | Raw unsigned sample |
| outValid | output | 1 | Corrected sample valid |
| outFirst | output | 1 | Corrected sample is channel 0 |
| outData | output | OUTW | Signed corrected sample |
| outSat | output | 1 | Output was clamped |
| frameErr | output | 1 | One-cycle pulse on an aborted frame |

## Verification
The bench targets the following corner cases and the fault each one exposes.

- **Half-count rounding of the baseline.** A design that drops the rounding leaves every output biased by about half a count.
- **Frame mean including the last sample, rounded on signed sums.** A design that uses a logical shift on a negative total, or reads the mean one sample early, gives offsets of many counts.
- **Back-to-back frames with the output paced by the next frame.** A design that writes before reading, or uses the new mean, emits the wrong frame's values.
- **Both rails of the clamp.** A missed rail wraps a large signal to the opposite sign.
- **An aborted frame.** A design that forgets to drop its buffered state emits stale data.
- **Both rescale divisors, including raw words below the offset.** A design that mishandles these wraps around instead of clamping at zero.

// File: rtl/strip_cm_pkg.sv
package strip_cm_pkg;

  // Per-sample strobes from control to datapath.
  typedef struct packed {
    logic take;     // sample accepted into the current frame
    logic train;    // accepted sample belongs to a training frame
    logic trFirst;  // first frame of a training window
    logic trLast;   // last frame of a training window
    logic emit;     // emit the buffered sample of the previous frame
    logic last;     // accepted sample is the final channel
  } cmStrobe_t;

endpackage

// File: rtl/strip_cm_ctrl.sv
module strip_cm_ctrl
  import strip_cm_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int TRAIN_LOG2 = 8,
  localparam int CHW       = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           inFirst,
  input  logic           trainMode,
  output cmStrobe_t      stb,
  output logic [CHW-1:0] chan,
  output logic           frameErr
);

  logic [CHW-1:0]        chCnt;
  logic                  active, frameTrain, bufFull;
  logic [TRAIN_LOG2-1:0] tFrm, tFrmEff;
  logic                  abortNow, isTrain, bufEff;

  always_comb begin
    abortNow    = inValid & inFirst & active;
    isTrain     = inFirst ? trainMode : frameTrain;
    chan        = inFirst ? '0 : chCnt;
    tFrmEff     = abortNow ? '0 : tFrm;
    bufEff      = abortNow ? 1'b0 : bufFull;
    stb.take    = inValid & (inFirst | active);
    stb.train   = stb.take & isTrain;
    stb.trFirst = (tFrmEff == '0);
    stb.trLast  = &tFrmEff;
    stb.emit    = stb.take & ~isTrain & bufEff;
    stb.last    = stb.take & (chan == CHW'(NCH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chCnt      <= '0;
      active     <= 1'b0;
      frameTrain <= 1'b0;
      bufFull    <= 1'b0;
      tFrm       <= '0;
      frameErr   <= 1'b0;
    end else begin
      frameErr <= abortNow;
      if (abortNow) begin
        bufFull <= 1'b0;
        tFrm    <= '0;
      end
      if (stb.take) begin
        chCnt      <= stb.last ? '0 : chan + CHW'(1);
        active     <= ~stb.last;
        frameTrain <= isTrain;
        if (stb.last) begin
          bufFull <= ~isTrain;
          tFrm    <= isTrain ? tFrmEff + TRAIN_LOG2'(1) : '0;
        end
      end
    end
  end

endmodule

// File: rtl/strip_cm_dp.sv
module strip_cm_dp
  import strip_cm_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int INW        = 10,
  parameter int OUTW       = 8,
  parameter int TRAIN_LOG2 = 8,
  parameter int RED_W      = 6,
  parameter int RED_OFFSET = 480,
  localparam int CHW       = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cmStrobe_t              stb,
  input  logic [CHW-1:0]         chan,
  input  logic [INW-1:0]         inData,
  input  logic                   reducedMode,
  input  logic                   divByTwo,
  output logic                   outValid,
  output logic                   outFirst,
  output logic signed [OUTW-1:0] outData,
  output logic                   outSat
);

  localparam int AW      = INW + TRAIN_LOG2;
  localparam int PW      = INW + 1;
  localparam int VW      = INW + 2;
  localparam int SW      = VW + CHW;
  localparam int DW      = VW + 1;
  localparam int RED_MAX = (1 << RED_W) - 1;
  localparam int OMAX    = (1 << (OUTW - 1)) - 1;
  localparam int OMIN    = -(1 << (OUTW - 1));

  logic [AW-1:0]        accMem   [NCH];
  logic [PW-1:0]        pedMem   [NCH];
  logic signed [VW-1:0] frameBuf [NCH];

  logic [INW-1:0]       diffRaw, quot, scaled;
  logic [AW-1:0]        sumNew;
  logic signed [VW-1:0] d2, v, meanReg;
  logic signed [SW-1:0] frameSum, sumBase, sumNext, sumRnd, meanFull;
  logic signed [DW-1:0] diff;

  // Optional rescale of the raw word into the narrow range.
  always_comb begin
    diffRaw = inData - INW'(RED_OFFSET);
    quot    = divByTwo ? (diffRaw >> 1) : (diffRaw / INW'(3));
    if (!reducedMode)                   scaled = inData;
    else if (inData < INW'(RED_OFFSET)) scaled = '0;
    else if (quot > INW'(RED_MAX))      scaled = INW'(RED_MAX);
    else                                scaled = quot;
  end

  // Baseline removal in half counts, then mean accumulation and clamp.
  always_comb begin
    sumNew  = stb.trFirst ? AW'(scaled) : accMem[chan] + AW'(scaled);
    d2      = $signed({1'b0, scaled, 1'b0}) - $signed({1'b0, pedMem[chan]}) + VW'(1);
    v       = d2 >>> 1;
    sumBase = frameSum;
    if (chan == '0) sumBase = '0;
    sumNext  = sumBase + SW'(v);
    sumRnd   = sumNext + SW'(NCH / 2);
    meanFull = sumRnd >>> CHW;
    diff     = DW'(frameBuf[chan]) - DW'(meanReg);
  end

  always_ff @(posedge clk) begin
    if (stb.train) begin
      accMem[chan] <= sumNew;
      if (stb.trLast) pedMem[chan] <= PW'(sumNew >> (TRAIN_LOG2 - 1));
    end
    if (stb.take && !stb.train) frameBuf[chan] <= v;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outData  <= '0;
      outSat   <= 1'b0;
      frameSum <= '0;
      meanReg  <= '0;
    end else begin
      outValid <= stb.emit;
      outFirst <= stb.emit && (chan == '0);
      if (stb.emit) begin
        if (diff > DW'(OMAX)) begin
          outData <= OUTW'(OMAX);
          outSat  <= 1'b1;
        end else if (diff < DW'(OMIN)) begin
          outData <= OUTW'(OMIN);
          outSat  <= 1'b1;
        end else begin
          outData <= OUTW'(diff);
          outSat  <= 1'b0;
        end
      end else begin
        outSat <= 1'b0;
      end
      if (stb.take && !stb.train) begin
        frameSum <= sumNext;
        if (stb.last) meanReg <= VW'(meanFull);
      end
    end
  end

endmodule

// File: rtl/strip_cm_corrector.sv
module strip_cm_corrector
  import strip_cm_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int INW        = 10,
  parameter int OUTW       = 8,
  parameter int TRAIN_LOG2 = 8,
  parameter int RED_W      = 6,
  parameter int RED_OFFSET = 480
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   trainMode,
  input  logic                   reducedMode,
  input  logic                   divByTwo,
  input  logic                   inValid,
  input  logic                   inFirst,
  input  logic [INW-1:0]         inData,
  output logic                   outValid,
  output logic                   outFirst,
  output logic signed [OUTW-1:0] outData,
  output logic                   outSat,
  output logic                   frameErr
);

  localparam int CHW = $clog2(NCH);

  cmStrobe_t      stb;
  logic [CHW-1:0] chan;

  strip_cm_ctrl #(
    .NCH(NCH),
    .TRAIN_LOG2(TRAIN_LOG2)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .inFirst(inFirst),
    .trainMode(trainMode),
    .stb(stb),
    .chan(chan),
    .frameErr(frameErr)
  );

  strip_cm_dp #(
    .NCH(NCH),
    .INW(INW),
    .OUTW(OUTW),
    .TRAIN_LOG2(TRAIN_LOG2),
    .RED_W(RED_W),
    .RED_OFFSET(RED_OFFSET)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .chan(chan),
    .inData(inData),
    .reducedMode(reducedMode),
    .divByTwo(divByTwo),
    .outValid(outValid),
    .outFirst(outFirst),
    .outData(outData),
    .outSat(outSat)
  );

endmodule

// File: rtl/strip_cm_corrector_chk.sv
module strip_cm_corrector_chk #(
  parameter int OUTW = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   trainMode,
  input logic                   inValid,
  input logic                   inFirst,
  input logic                   outValid,
  input logic                   outFirst,
  input logic signed [OUTW-1:0] outData,
  input logic                   outSat,
  input logic                   frameErr
);

  localparam logic signed [OUTW-1:0] OMAX = OUTW'((1 << (OUTW - 1)) - 1);
  localparam logic signed [OUTW-1:0] OMIN = OUTW'(-(1 << (OUTW - 1)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !frameErr && !outSat));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> $past(inValid && inFirst));

  // R9
  out_paced_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R6
  first_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid);

  // R6
  no_train_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !$past(inValid && inFirst && trainMode));

  // R7
  sat_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSat |-> (outValid && (outData == OMAX || outData == OMIN)));

endmodule

bind strip_cm_corrector strip_cm_corrector_chk #(.OUTW(OUTW)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .trainMode(trainMode),
  .inValid(inValid),
  .inFirst(inFirst),
  .outValid(outValid),
  .outFirst(outFirst),
  .outData(outData),
  .outSat(outSat),
  .frameErr(frameErr)
);

// File: tb/strip_cm_corrector_tb.sv
module strip_cm_corrector_tb;

  localparam int NCH  = 128;
  localparam int INW  = 10;
  localparam int OUTW = 8;
  localparam int TL   = 4;
  localparam int TRN  = 1 << TL;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                   rstN = 1'b0;
  logic                   trainMode = 1'b0, reducedMode = 1'b0, divByTwo = 1'b0;
  logic                   inValid = 1'b0, inFirst = 1'b0;
  logic [INW-1:0]         inData = '0;
  logic                   outValid, outFirst, outSat, frameErr;
  logic signed [OUTW-1:0] outData;

  strip_cm_corrector #(.NCH(NCH), .INW(INW), .OUTW(OUTW), .TRAIN_LOG2(TL)) u_dut (
    .clk(clk), .rstN(rstN), .trainMode(trainMode), .reducedMode(reducedMode),
    .divByTwo(divByTwo), .inValid(inValid), .inFirst(inFirst), .inData(inData),
    .outValid(outValid), .outFirst(outFirst), .outData(outData), .outSat(outSat),
    .frameErr(frameErr)
  );

  int total = 0, bad = 0;

  // Reference model state
  int acc [NCH];
  int ped2 [NCH];
  int expCur [NCH];
  bit satCur [NCH];
  int frm [NCH];
  int trainCnt = 0;
  bit bufFull = 0, pendAbort = 0;

  // Expectations for the cycle after the last drive
  bit pEmit = 0, pFirst = 0, pSat = 0, pErr = 0;
  int pData = 0;
  string pTag = "R1", pVTag = "R1";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic checkPending();
    chk(outValid == pEmit, pVTag, "outValid", int'(outValid), int'(pEmit));
    if (pEmit) begin
      chk(int'(outData) == pData, pTag, "outData", int'(outData), pData);
      chk(outSat == pSat, "R7", "outSat", int'(outSat), int'(pSat));
      chk(outFirst == pFirst, "R6", "outFirst", int'(outFirst), int'(pFirst));
    end
    chk(frameErr == pErr, "R8", "frameErr", int'(frameErr), int'(pErr));
  endtask

  task automatic step(input bit v, input bit f, input int d, input bit e, input bit fst,
                      input int ed, input bit es, input bit er, input string tag, input string vtag);
    @(negedge clk);
    checkPending();
    inValid = v; inFirst = f; inData = INW'(d);
    pEmit = e; pFirst = fst; pData = ed; pSat = es; pErr = er; pTag = tag; pVTag = vtag;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9", "R9");
  endtask

  function automatic int scaleF(input int x);
    int q;
    if (!reducedMode) return x;
    if (x < 480) return 0;
    q = (x - 480) / (divByTwo ? 2 : 3);
    return (q > 63) ? 63 : q;
  endfunction

  task automatic fillRand(input int base, input int spread, input int offs);
    for (int k = 0; k < NCH; k++) begin
      int x;
      x = base + int'($urandom % spread) + offs;
      frm[k] = (x > 1023) ? 1023 : ((x < 0) ? 0 : x);
    end
  endtask

  task automatic runFrame(input bit train, input int nSend, input bit gaps, input string tag);
    int vArr [NCH];
    int s, sc, m, d;
    bit emitF;
    trainMode = train;
    if (pendAbort) begin
      bufFull = 0;
      trainCnt = 0;
    end
    emitF = !train && bufFull;
    s = 0;
    for (int k = 0; k < nSend; k++) begin
      if (gaps && (k % 7 == 3)) idle();
      step(1, k == 0, frm[k], emitF, k == 0, expCur[k], satCur[k], (k == 0) && pendAbort, tag, "R6");
      sc = scaleF(frm[k]);
      if (train) begin
        acc[k] = (trainCnt == 0) ? sc : acc[k] + sc;
        if (trainCnt == TRN - 1) ped2[k] = acc[k] >>> (TL - 1);
      end else begin
        vArr[k] = (2 * sc - ped2[k] + 1) >>> 1;
        s += vArr[k];
      end
    end
    pendAbort = 0;
    if (nSend < NCH) begin
      pendAbort = 1;
      return;
    end
    if (train) begin
      trainCnt = (trainCnt + 1) % TRN;
      bufFull = 0;
    end else begin
      m = (s + 64) >>> 7;
      for (int k = 0; k < NCH; k++) begin
        d = vArr[k] - m;
        satCur[k] = (d > 127) || (d < -128);
        expCur[k] = (d > 127) ? 127 : ((d < -128) ? -128 : d);
      end
      bufFull = 1;
      trainCnt = 0;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NCH; k++) begin
      acc[k] = 0; ped2[k] = 0; expCur[k] = 0; satCur[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(outValid == 0, "R1", "outValid", int'(outValid), 0);
    chk(outFirst == 0, "R1", "outFirst", int'(outFirst), 0);
    chk(outSat == 0, "R1", "outSat", int'(outSat), 0);
    chk(frameErr == 0, "R1", "frameErr", int'(frameErr), 0);

    // R3 training, full precision, one frame with gaps (R9)
    for (int f = 0; f < TRN; f++) begin
      fillRand(490, 20, 0);
      runFrame(1, NCH, f == 3, "R3");
    end
    // R6: first run frame after training emits nothing
    fillRand(490, 20, 0);
    runFrame(0, NCH, 0, "R3");
    fillRand(480, 40, 0);
    runFrame(0, NCH, 1, "R3");
    // R4 and R5: random frames, then a shared offset
    fillRand(490, 20, 40);
    runFrame(0, NCH, 0, "R4");
    fillRand(470, 60, -25);
    runFrame(0, NCH, 0, "R5");
    // R7: both rails
    fillRand(490, 20, 0);
    frm[0] = 1023; frm[1] = 0; frm[2] = 800;
    runFrame(0, NCH, 0, "R5");
    fillRand(490, 20, 0);
    runFrame(0, NCH, 0, "R7");
    // R8: abort after 50 samples
    fillRand(490, 20, 0);
    runFrame(0, 50, 0, "R8");
    fillRand(490, 20, 0);
    runFrame(0, NCH, 0, "R8");
    fillRand(490, 20, 0);
    runFrame(0, NCH, 0, "R8");

    // R2: reduced precision, divide by 3
    reducedMode = 1'b1;
    divByTwo = 1'b0;
    for (int f = 0; f < TRN; f++) begin
      fillRand(400, 620, 0);
      runFrame(1, NCH, 0, "R2");
    end
    for (int f = 0; f < 3; f++) begin
      fillRand(400, 620, 0);
      runFrame(0, NCH, f == 1, "R2");
    end

    // R2: reduced precision, divide by 2
    divByTwo = 1'b1;
    for (int f = 0; f < TRN; f++) begin
      fillRand(470, 150, 0);
      runFrame(1, NCH, 0, "R2");
    end
    for (int f = 0; f < 3; f++) begin
      fillRand(470, 150, 0);
      runFrame(0, NCH, 0, "R2");
    end

    idle();
    idle();
    @(negedge clk);
    checkPending();
    summary();
    $finish;
  end

endmodule